// File: doc/BRIEF.md
# Transmit Slot Launch Arbiter

This block holds four queued transmit slot registers: three location slots and one command slot. It also keeps the busy mask for those slots. Each slot register carries an enable flag and a halfword pointer to a frame header in a packet buffer. When a launch strobe arrives, the block works out which slots are eligible and picks one of them by a fixed priority. It then reads that slot's header through a one-cycle-latency read port. The result is the slot index, the byte address, the payload length, the on-air length and the rate, presented with a single-cycle valid pulse.

The busy mask is owned by this block. A launch ORs every eligible slot into it, not only the chosen one. The transmit engine clears bits through a clear mask when a transfer ends. From the busy mask and a beacon-active input, the block also produces a one-hot selector that names the slot to be serviced on each timer tick.

Top module: `tx_slot_arbiter`

## Requirements
- R1: After reset the busy mask is 0, no valid pulse is produced, and all four slot registers are 0, so every slot is disabled.
- R2: Writing `cfg_wdata` with `cfg_we` high stores it in the slot register selected by `cfg_sel`. Bit 15 is the enable flag and bits 11:0 are a halfword pointer. Bits 14:12 are ignored. The reported byte address is the pointer shifted left by one.
- R3: Slot indices are 0 for location slot 1, 1 for the command slot, 2 for location slot 2 and 3 for location slot 3. The same index selects the register on `cfg_sel`, the bit in `req_mask`, the bit in `busy`, `clr_busy`, and the value of `go_slot`. The eligible set is enable AND `req_mask` AND NOT `busy`.
- R4: Exactly one eligible slot launches per decision. The order is location 3, then location 2, then the command slot, then location 1, which is index 3 down to index 0.
- R5: On a launch with a non-empty eligible set, the whole eligible set is ORed into `busy` at the launch edge.
- R6: A launch with an empty eligible set produces no valid pulse and leaves `busy` unchanged.
- R7: `go_len` is the low 14 bits of the 16-bit word at byte offset 0xA of the header. `go_air_len` is 12 plus `go_len`. Header reads use even byte addresses.
- R8: The rate byte is the low byte of the word at byte offset 0x8 of the header. A value of 0x14 gives `go_rate` = 2 and any other value gives `go_rate` = 1. The high byte of that word has no effect.
- R9: `go_valid` is high for exactly one cycle, in the fourth cycle after the clock edge that samples `launch`.
- R10: Each set bit of `clr_busy` clears the matching `busy` bit at the next edge.
- R11: `serve_sel` is one-hot or zero. Bit 4 is set when `beacon_busy` is high. Otherwise the set bit is the highest set bit of `busy` (bits 3..0). When neither the beacon nor any slot is busy, `serve_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot register write strobe |
| cfg_sel | input | 2 | Slot index to write |
| cfg_wdata | input | 16 | Slot register value |
| req_mask | input | 4 | Per-slot transmit request |
| clr_busy | input | 4 | Per-slot busy clear |
| launch | input | 1 | Single-cycle launch decision strobe |
| beacon_busy | input | 1 | Beacon transfer in progress |
| mem_rd_en | output | 1 | Header read enable |
| mem_rd_addr | output | PTR_W+1 | Header read byte address |
| mem_rd_data | input | 16 | Read word, valid one cycle after the request |
| go_valid | output | 1 | Launch result valid pulse |
| go_slot | output | 2 | Launched slot index |
| go_addr | output | PTR_W+1 | Header byte address |
| go_len | output | LEN_W | Payload length |
| go_air_len | output | LEN_W+1 | Payload length plus 12 |
| go_rate | output | 2 | Rate, 1 or 2 |
| busy | output | 4 | Busy mask |
| serve_sel | output | 5 | One-hot service selector |

## Verification
The main sweep covers every combination of preset busy mask, enable set and request set: 16 values each, 4096 cases in all. This separates the three eligibility terms from each other. It also shows that the winner follows the location-3-first order and not the numeric order, and that the busy mask takes in the whole eligible set rather than only the winner. A second sweep runs all 256 rate byte values with a distracting high byte and varying length words. It confirms that only the exact code 0x14 selects the fast rate and that the 14-bit length mask is applied. The service selector is checked against every preset busy mask with the beacon both active and idle.

// File: rtl/tx_slot_arbiter.sv
module tx_slot_arbiter #(
  parameter int PTR_W = 12,
  parameter int LEN_W = 14,
  parameter logic [7:0] FAST_CODE = 8'h14,
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic [3:0]        req_mask,
  input  logic [3:0]        clr_busy,
  input  logic              launch,
  input  logic              beacon_busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [15:0]       mem_rd_data,
  output logic              go_valid,
  output logic [1:0]        go_slot,
  output logic [ADDR_W-1:0] go_addr,
  output logic [LEN_W-1:0]  go_len,
  output logic [LEN_W:0]    go_air_len,
  output logic [1:0]        go_rate,
  output logic [3:0]        busy,
  output logic [4:0]        serve_sel
);

  typedef enum logic [1:0] {S_IDLE, S_LEN, S_RATE, S_LAST} state_t;

  state_t                state;
  logic [15:0]           slot_q [4];
  logic [3:0]            en;
  logic [3:0]            cand;
  logic [1:0]            pick;
  logic                  launch_ok;
  logic [1:0]            sel_q;
  logic [ADDR_W-1:0]     base_q;
  logic [LEN_W-1:0]      len_q;

  for (genvar i = 0; i < 4; i++) begin : g_en
    assign en[i] = slot_q[i][15];
  end

  assign cand      = en & req_mask & ~busy;
  assign launch_ok = launch && (state == S_IDLE) && (cand != 4'd0);

  always_comb begin
    if (cand[3])      pick = 2'd3;
    else if (cand[2]) pick = 2'd2;
    else if (cand[1]) pick = 2'd1;
    else              pick = 2'd0;
  end

  always_comb begin
    if (beacon_busy)  serve_sel = 5'b10000;
    else if (busy[3]) serve_sel = 5'b01000;
    else if (busy[2]) serve_sel = 5'b00100;
    else if (busy[1]) serve_sel = 5'b00010;
    else if (busy[0]) serve_sel = 5'b00001;
    else              serve_sel = 5'b00000;
  end

  assign mem_rd_en   = (state == S_LEN) || (state == S_RATE);
  assign mem_rd_addr = base_q + ((state == S_LEN) ? ADDR_W'(10) : ADDR_W'(8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) slot_q[i] <= '0;
    end else if (cfg_we) begin
      slot_q[cfg_sel] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy | (launch_ok ? cand : 4'd0)) & ~clr_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sel_q      <= '0;
      base_q     <= '0;
      len_q      <= '0;
      go_valid   <= 1'b0;
      go_slot    <= '0;
      go_addr    <= '0;
      go_len     <= '0;
      go_air_len <= '0;
      go_rate    <= 2'd1;
    end else begin
      go_valid <= 1'b0;
      case (state)
        S_IDLE: if (launch_ok) begin
          sel_q  <= pick;
          base_q <= {slot_q[pick][PTR_W-1:0], 1'b0};
          state  <= S_LEN;
        end
        S_LEN:  state <= S_RATE;
        S_RATE: begin
          len_q <= mem_rd_data[LEN_W-1:0];
          state <= S_LAST;
        end
        S_LAST: begin
          go_valid   <= 1'b1;
          go_slot    <= sel_q;
          go_addr    <= base_q;
          go_len     <= len_q;
          go_air_len <= (LEN_W+1)'(len_q) + (LEN_W+1)'(12);
          go_rate    <= (mem_rd_data[7:0] == FAST_CODE) ? 2'd2 : 2'd1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_empty_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && state == S_IDLE && cand == 4'd0 && clr_busy == 4'd0) |=> busy == $past(busy));

  assert_busy_absorbs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_ok && clr_busy == 4'd0) |=> ((busy & $past(cand)) == $past(cand)));

  assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy != 4'd0) |=> ((busy & $past(clr_busy)) == 4'd0));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |=> !go_valid);

  assert_rate_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |-> (go_rate == 2'd1 || go_rate == 2'd2));

  assert_even_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !mem_rd_addr[0]);

  assert_serve_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(serve_sel) && ((beacon_busy || busy != 4'd0) == (serve_sel != 5'd0)));

endmodule

// File: tb/tx_slot_arbiter_bench.sv
module tx_slot_arbiter_bench;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0] req_mask = '0, clr_busy = '0;
  logic launch = 1'b0, beacon_busy = 1'b0;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic go_valid;
  logic [1:0] go_slot;
  logic [AW-1:0] go_addr;
  logic [13:0] go_len;
  logic [14:0] go_air_len;
  logic [1:0] go_rate;
  logic [3:0] busy;
  logic [4:0] serve_sel;

  int checks = 0, errors = 0;
  logic [15:0] mem [0:255];

  always #4 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[8:1]];

  tx_slot_arbiter u_tx_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_mask(req_mask), .clr_busy(clr_busy), .launch(launch), .beacon_busy(beacon_busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .go_valid(go_valid), .go_slot(go_slot), .go_addr(go_addr), .go_len(go_len),
    .go_air_len(go_air_len), .go_rate(go_rate), .busy(busy), .serve_sel(serve_sel)
  );

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ptr_of(input int i);
    return 12'(32 * (i + 1));
  endfunction

  function automatic logic [15:0] lenw_of(input int i);
    return 16'hC000 | 16'((i + 1) * 291 + 7);
  endfunction

  function automatic logic [15:0] ratew_of(input int i);
    case (i)
      0: return 16'h5514;
      1: return 16'h140A;
      2: return 16'h0014;
      default: return 16'h00FF;
    endcase
  endfunction

  task automatic write_slot(input int i, input bit en);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 2'(i);
    cfg_wdata = {en, 3'b111, ptr_of(i)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_enables(input logic [3:0] m);
    for (int i = 0; i < 4; i++) write_slot(i, m[i]);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_busy = 4'hF;
    @(negedge clk);
    clr_busy = 4'h0;
  endtask

  logic [3:0] busy_after;
  int pulses;
  int pulse_k;
  logic [1:0] s_slot;
  logic [AW-1:0] s_addr;
  logic [13:0] s_len;
  logic [14:0] s_air;
  logic [1:0] s_rate;

  task automatic do_launch();
    @(negedge clk);
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    busy_after = busy;
    pulses = 0;
    pulse_k = -1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (go_valid) begin
        pulses++;
        pulse_k = k;
        s_slot = go_slot; s_addr = go_addr; s_len = go_len; s_air = go_air_len; s_rate = go_rate;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
    for (int i = 0; i < 4; i++) begin
      mem[ptr_of(i) + 5] = lenw_of(i);
      mem[ptr_of(i) + 4] = ratew_of(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 4'h0, "R1 busy after reset", busy, 0);
    check(go_valid == 1'b0, "R1 valid after reset", go_valid, 0);
    req_mask = 4'hF;
    do_launch();
    check(pulses == 0, "R1 slots disabled after reset", pulses, 0);
    check(busy_after == 4'h0, "R1 busy stays clear", busy_after, 0);

    for (int pre = 0; pre < 16; pre++) begin
      for (int en = 0; en < 16; en++) begin
        for (int rq = 0; rq < 16; rq++) begin
          logic [3:0] cand;
          logic [3:0] expb;
          int win;
          clear_all();
          if (pre != 0) begin
            set_enables(4'(pre));
            req_mask = 4'(pre);
            do_launch();
          end
          check(busy == 4'(pre), "R10/R5 busy preset", busy, pre);
          if (en == 0 && rq == 0) begin
            beacon_busy = 1'b0;
            #1;
            check(serve_sel == ((pre == 0) ? 5'd0 :
                  (pre >= 8) ? 5'd8 : (pre >= 4) ? 5'd4 : (pre >= 2) ? 5'd2 : 5'd1),
                  "R11 serve order", serve_sel, pre);
            beacon_busy = 1'b1;
            #1;
            check(serve_sel == 5'b10000, "R11 beacon first", serve_sel, 16);
            beacon_busy = 1'b0;
          end
          set_enables(4'(en));
          req_mask = 4'(rq);
          do_launch();
          cand = 4'(en) & 4'(rq) & ~4'(pre);
          expb = 4'(pre) | cand;
          win = cand[3] ? 3 : cand[2] ? 2 : cand[1] ? 1 : 0;
          check(busy_after == expb, "R5/R3 busy after launch", busy_after, expb);
          if (cand == 0) begin
            check(pulses == 0, "R6 no pulse when none eligible", pulses, 0);
          end else begin
            check(pulses == 1 && pulse_k == 3, "R9 pulse timing", pulse_k, 3);
            check(s_slot == 2'(win), "R4 priority winner", s_slot, win);
            check(s_addr == AW'({ptr_of(win), 1'b0}), "R2 byte address", s_addr, {ptr_of(win), 1'b0});
            check(s_len == lenw_of(win)[13:0], "R7 length", s_len, lenw_of(win)[13:0]);
            check(s_air == 15'(lenw_of(win)[13:0]) + 15'd12, "R7 air length", s_air, lenw_of(win)[13:0] + 12);
            check(s_rate == ((ratew_of(win)[7:0] == 8'h14) ? 2'd2 : 2'd1), "R8 rate", s_rate, win);
          end
        end
      end
    end

    for (int r = 0; r < 256; r++) begin
      logic [15:0] lw;
      lw = 16'(r * 67) ^ 16'hA5F0;
      mem[ptr_of(3) + 4] = {~8'(r), 8'(r)};
      mem[ptr_of(3) + 5] = lw;
      clear_all();
      set_enables(4'b1000);
      req_mask = 4'b1000;
      do_launch();
      check(pulses == 1, "R9 single pulse", pulses, 1);
      check(s_rate == ((r == 8'h14) ? 2'd2 : 2'd1), "R8 rate byte sweep", s_rate, r);
      check(s_len == lw[13:0], "R7 length mask", s_len, lw[13:0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule